// File: doc/BRIEF.md
# Timer Compare Soft-Interrupt Unit

This block keeps a free-running 64-bit tick counter and three compare registers that watch it. When an enabled compare register matches the count, the block raises an interrupt. The tick compare sets soft-interrupt bit 0. The system compare sets soft-interrupt bit 16. The hypervisor compare drives a separate sticky output and leaves the soft-interrupt register alone.

Software reaches every register through a synchronous register port with address, write enable and write data; read data is combinational from the address. The soft-interrupt register can be written whole, or changed one bit at a time through a set alias or a clear alias. The level interrupt request is the OR of all soft-interrupt bits.

Address map: 0 tick counter, 1 soft-interrupt direct write, 2 set alias, 3 clear alias, 4 tick compare, 5 system compare, 6 hypervisor compare, 7 reads zero. A read of address 1, 2 or 3 returns the soft-interrupt register.

Top module: `tick_cmp_intc`

## Requirements
- R1: While reset is low, the counter and the soft-interrupt register read 0, `irq_o` and `hyp_irq_o` are 0, and every compare register reads `64'h8000_0000_0000_0000` (disabled).
- R2: The counter adds one to bits 62:0 on every clock, wrapping to zero, and keeps bit 63 unchanged. A write to address 0 loads all 64 bits instead.
- R3: A write to address 1 replaces the soft-interrupt register with write-data bits SOFT_W-1:0 (17 bits by default). Higher data bits are dropped.
- R4: A write to address 2 ORs write-data bits SOFT_W-1:0 into the soft-interrupt register. Zero bits leave it unchanged.
- R5: A write to address 3 gives new = old AND NOT write-data.
- R6: A compare register stores all 64 written bits and reads them back. Bit 63 is the disable flag and bits 62:0 are the compare value.
- R7: A compare matches only while its bit 63 is 0 and its bits 62:0 equal counter bits 62:0. Counter bit 63 is ignored. A tick-compare match sets soft-interrupt bit 0 on the following clock edge.
- R8: A system-compare match sets soft-interrupt bit 16 on the following edge, so `irq_o` rises then.
- R9: A hypervisor-compare match sets `hyp_irq_o` on the following edge and leaves the soft-interrupt register unchanged. `hyp_irq_o` stays high until address 6 is written, and that write clears it.
- R10: A compare value written equal to the current count, or behind it, does not fire on the following cycles. It fires only when the counter later reaches it again.
- R11: `irq_o` is 1 exactly when any soft-interrupt bit is 1.
- R12: When a hardware match and a software write hit the soft-interrupt register on the same edge, the match bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write enable |
| addr_i | input | 3 | Register address |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data for `addr_i` |
| softint_o | output | 17 | Soft-interrupt register |
| irq_o | output | 1 | Level interrupt request (OR of soft-interrupt bits) |
| hyp_irq_o | output | 1 | Sticky hypervisor compare-match interrupt |

## Verification
The hardest case to reach is a compare match that lands on the same clock edge as a software write to the soft-interrupt register. A second hard case is a compare value that must stay silent because it is not ahead of the count.

The stimulus controls time through the counter itself. It loads the counter with a known value a fixed number of cycles before the compare value, then counts edges exactly. A write can then be placed on the very edge of the match, or a compare can be written equal to the live count. The counter is then rewound so that the same compare value is reached later.

// File: rtl/tcsi_pkg.sv
package tcsi_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 64;
  localparam int SOFT_W = 17;
  localparam int CMP_N  = 3;

  localparam logic [ADDR_W-1:0] A_CNT  = 3'd0;
  localparam logic [ADDR_W-1:0] A_SOFT = 3'd1;
  localparam logic [ADDR_W-1:0] A_SET  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CLR  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CMP0 = 3'd4;  // 4 tick, 5 system, 6 hypervisor

  localparam int HIT_TICK = 0;
  localparam int HIT_SYS  = 1;
  localparam int HIT_HYP  = 2;
endpackage

// File: rtl/tcsi_counter.sv
module tcsi_counter #(
  parameter int W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wd_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_o <= '0;
    else if (we_i) cnt_o <= wd_i;
    else           cnt_o <= {cnt_o[W-1], cnt_o[W-2:0] + (W-1)'(1)};
  end

  a_r2_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> (cnt_o[W-2:0] == $past(cnt_o[W-2:0]) + (W-1)'(1)) &&
              (cnt_o[W-1] == $past(cnt_o[W-1])));
endmodule

// File: rtl/tcsi_cmp.sv
module tcsi_cmp #(
  parameter int W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wd_i,
  input  logic [W-1:0] cnt_i,
  output logic [W-1:0] val_o,
  output logic         hit_o
);
  localparam logic [W-1:0] RST_VAL = {1'b1, {(W-1){1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   val_o <= RST_VAL;
    else if (we_i) val_o <= wd_i;
  end

  // top bit disables; counter top bit is not compared
  assign hit_o = !val_o[W-1] && (val_o[W-2:0] == cnt_i[W-2:0]);

  a_r6_cmp_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> val_o == $past(wd_i));
endmodule

// File: rtl/tcsi_softint.sv
module tcsi_softint #(
  parameter int SW       = 17,
  parameter int TICK_BIT = 0,
  parameter int SYS_BIT  = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          set_i,
  input  logic          clr_i,
  input  logic [SW-1:0] wd_i,
  input  logic          hit_tick_i,
  input  logic          hit_sys_i,
  output logic [SW-1:0] si_o
);
  logic [SW-1:0] sw_val, hw_set, si_d;

  always_comb begin
    if (wr_i)       sw_val = wd_i;
    else if (set_i) sw_val = si_o | wd_i;
    else if (clr_i) sw_val = si_o & ~wd_i;
    else            sw_val = si_o;
    hw_set = '0;
    hw_set[TICK_BIT] = hit_tick_i;
    hw_set[SYS_BIT]  = hit_sys_i;
    si_d = sw_val | hw_set;  // hardware set wins over a same-edge write
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) si_o <= '0;
    else         si_o <= si_d;
  end

  a_r4_set_or: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i && !hit_tick_i && !hit_sys_i |=> si_o == $past(si_o | wd_i));
  a_r5_clr_andn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !hit_tick_i && !hit_sys_i |=> si_o == $past(si_o & ~wd_i));
  a_r8_sys_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_sys_i |=> si_o[SYS_BIT]);
  a_r12_tick_bit_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_tick_i && (wr_i || clr_i) |=> si_o[TICK_BIT]);
endmodule

// File: rtl/tick_cmp_intc.sv
module tick_cmp_intc
  import tcsi_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int SW = SOFT_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [SW-1:0] softint_o,
  output logic          irq_o,
  output logic          hyp_irq_o
);
  logic [DW-1:0] cnt;
  logic [DW-1:0] cmp_val [CMP_N];
  logic [CMP_N-1:0] hit, cmp_we;

  tcsi_counter #(.W(DW)) u_cnt (
    .clk_i, .rst_ni,
    .we_i (we_i && addr_i == A_CNT),
    .wd_i (wdata_i),
    .cnt_o(cnt)
  );

  for (genvar g = 0; g < CMP_N; g++) begin : g_cmp
    assign cmp_we[g] = we_i && (addr_i == A_CMP0 + AW'(g));
    tcsi_cmp #(.W(DW)) u_cmp (
      .clk_i, .rst_ni,
      .we_i (cmp_we[g]),
      .wd_i (wdata_i),
      .cnt_i(cnt),
      .val_o(cmp_val[g]),
      .hit_o(hit[g])
    );
  end

  tcsi_softint #(.SW(SW), .TICK_BIT(0), .SYS_BIT(16)) u_si (
    .clk_i, .rst_ni,
    .wr_i      (we_i && addr_i == A_SOFT),
    .set_i     (we_i && addr_i == A_SET),
    .clr_i     (we_i && addr_i == A_CLR),
    .wd_i      (wdata_i[SW-1:0]),
    .hit_tick_i(hit[HIT_TICK]),
    .hit_sys_i (hit[HIT_SYS]),
    .si_o      (softint_o)
  );

  // sticky until the hypervisor compare register is rewritten
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               hyp_irq_o <= 1'b0;
    else if (cmp_we[HIT_HYP])  hyp_irq_o <= 1'b0;
    else if (hit[HIT_HYP])     hyp_irq_o <= 1'b1;
  end

  assign irq_o = |softint_o;

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_CNT)                           rdata_o = cnt;
    else if (addr_i == A_SOFT || addr_i == A_SET ||
             addr_i == A_CLR)                      rdata_o = {{(DW-SW){1'b0}}, softint_o};
    else if (addr_i == A_CMP0)                     rdata_o = cmp_val[0];
    else if (addr_i == A_CMP0 + AW'(1))            rdata_o = cmp_val[1];
    else if (addr_i == A_CMP0 + AW'(2))            rdata_o = cmp_val[2];
  end

  a_r9_hyp_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit[HIT_HYP] && !cmp_we[HIT_HYP] |=> hyp_irq_o);
  a_r9_hyp_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_we[HIT_HYP] |=> !hyp_irq_o);
  a_r9_hyp_no_soft: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i && !hit[HIT_TICK] && !hit[HIT_SYS] |=> $stable(softint_o));
endmodule

// File: tb/tick_cmp_intc_bench.sv
`timescale 1ns/1ps
module tick_cmp_intc_bench;
  logic        clk = 0;
  logic        rst_ni = 0;
  logic        we = 0;
  logic [2:0]  addr = 0;
  logic [63:0] wd = 0;
  logic [63:0] rdata;
  logic [16:0] softint;
  logic        irq, hyp_irq;
  int checks = 0, errors = 0;

  localparam logic [63:0] DIS = 64'h8000_0000_0000_0000;

  always #5 clk = ~clk;

  tick_cmp_intc u_tick_cmp_intc (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we), .addr_i(addr), .wdata_i(wd),
    .rdata_o(rdata), .softint_o(softint), .irq_o(irq), .hyp_irq_o(hyp_irq)
  );

  localparam int NV = 8;
  localparam logic [2:0]  V_ADDR [NV] = '{3'd1, 3'd2, 3'd3, 3'd2, 3'd3, 3'd1, 3'd3, 3'd2};
  localparam logic [63:0] V_DATA [NV] = '{64'h0F0F0, 64'h5, 64'hF0, 64'h10000,
                                          64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFE_0001,
                                          64'h0, 64'h0};
  localparam logic [16:0] V_EXP  [NV] = '{17'h0F0F0, 17'h0F0F5, 17'h0F005, 17'h1F005,
                                          17'h0, 17'h1, 17'h1, 17'h1};

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    @(negedge clk);
    we = 1; addr = a; wd = d;
    @(negedge clk);
    we = 0; wd = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [63:0] d);
    addr = a; #1; d = rdata;
  endtask

  initial begin
    logic [63:0] v, v2;
    repeat (3) @(negedge clk);
    rd(3'd0, v); check("R1 counter", v, 0);
    check("R1 softint", {47'd0, softint}, 0);
    check("R1 irq", {63'd0, irq}, 0);
    check("R1 hyp", {63'd0, hyp_irq}, 0);
    for (int i = 4; i < 7; i++) begin
      rd(3'(i), v); check("R1 compare reset", v, DIS);
    end
    rst_ni = 1;
    @(negedge clk);
    rd(3'd0, v); @(negedge clk); rd(3'd0, v2);
    check("R2 step", v2, v + 1);

    for (int i = 0; i < NV; i++) begin
      wr(V_ADDR[i], V_DATA[i]);
      check("R3/R4/R5 softint vector", {47'd0, softint}, {47'd0, V_EXP[i]});
      check("R11 irq level", {63'd0, irq}, {63'd0, V_EXP[i] != 0});
    end
    wr(3'd3, '1);

    wr(3'd5, 64'h8000_0000_1234_5678);
    rd(3'd5, v); check("R6 readback", v, 64'h8000_0000_1234_5678);

    wr(3'd0, 64'hFFFF_FFFF_FFFF_FFFE);
    @(negedge clk); @(negedge clk);
    rd(3'd0, v); check("R2 wrap keeps bit 63", v, DIS);

    // R7 disabled compare never fires
    wr(3'd4, DIS | 64'd103);
    wr(3'd0, 64'd100);
    repeat (6) @(negedge clk);
    check("R7 disabled", {47'd0, softint}, 0);
    // R7 enabled, counter bit 63 ignored
    wr(3'd4, 64'd203);
    wr(3'd0, DIS | 64'd200);
    repeat (3) @(negedge clk);
    check("R7 before match", {47'd0, softint}, 0);
    @(negedge clk);
    check("R7 tick bit", {47'd0, softint}, 1);
    wr(3'd4, DIS);
    wr(3'd3, '1);

    // R8 system compare
    wr(3'd5, 64'd303);
    wr(3'd0, 64'd300);
    repeat (3) @(negedge clk);
    check("R8 before match", {63'd0, irq}, 0);
    @(negedge clk);
    check("R8 sys bit", {47'd0, softint}, 64'h10000);
    check("R8 irq", {63'd0, irq}, 1);
    wr(3'd5, DIS);
    wr(3'd3, '1);

    // R10 compare equal to live count, then one behind it
    wr(3'd0, 64'd1000);
    wr(3'd5, 64'd1001);
    repeat (8) @(negedge clk);
    check("R10 equal not fired", {47'd0, softint}, 0);
    wr(3'd5, 64'd500);
    repeat (4) @(negedge clk);
    check("R10 past not fired", {47'd0, softint}, 0);
    wr(3'd5, 64'd1001);
    wr(3'd0, 64'd998);
    repeat (3) @(negedge clk);
    check("R10 not yet", {47'd0, softint}, 0);
    @(negedge clk);
    check("R10 later fire", {47'd0, softint}, 64'h10000);
    wr(3'd5, DIS);
    wr(3'd3, '1);

    // R12 clear write on the match edge
    wr(3'd5, 64'd403);
    wr(3'd0, 64'd400);
    repeat (2) @(negedge clk);
    wr(3'd3, 64'h10000);
    check("R12 set wins", {47'd0, softint}, 64'h10000);
    wr(3'd5, DIS);
    wr(3'd3, '1);

    // R9 hypervisor compare
    wr(3'd6, 64'd503);
    wr(3'd0, 64'd500);
    repeat (3) @(negedge clk);
    check("R9 before match", {63'd0, hyp_irq}, 0);
    @(negedge clk);
    check("R9 hyp raised", {63'd0, hyp_irq}, 1);
    check("R9 softint untouched", {47'd0, softint}, 0);
    repeat (5) @(negedge clk);
    check("R9 hyp held", {63'd0, hyp_irq}, 1);
    wr(3'd6, DIS);
    check("R9 hyp cleared by write", {63'd0, hyp_irq}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog (all requirements): run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule